// File: doc/BRIEF.md
# Multi-Mode Effective Address Unit

This unit works out where one instruction's operand lives, and what its value is, under one of eight addressing modes. A request carries a 3-bit mode code and a small offset/immediate field from the instruction. It also carries the value read from the register file, the stack pointer and the program counter. The unit adds a base and an offset where the mode needs it. It then issues zero, one or two reads through a single-port memory read interface and reports the final effective address and operand with a one-cycle done strobe.

Modes that use memory as a pointer chain two reads. The first read returns a pointer and the second read, at that pointer, returns the data. Only one read is ever outstanding, and the memory may take any number of cycles to answer. A new request is taken only while the unit is idle, which includes the cycle in which the previous result is reported.

Top module: `eaddr_resolver`

## Requirements
- R1: During and right after a synchronous active-high reset: req_ready=1, done=0, mem_req=0, ea_out=0, operand_out=0.
- R2: Mode 0 (immediate): operand_out is the field sign-extended to the data width, ea_out is 0, no memory read is issued, and done is high in the cycle after the request is accepted.
- R3: Mode 1 (register): operand_out equals reg_val and ea_out is 0, with no memory read.
- R4: Mode 2 (direct): one read at the zero-extended field; ea_out is that address and operand_out is the returned data.
- R5: Mode 3 (register indirect): one read at reg_val; ea_out is reg_val and operand_out is the returned data.
- R6: Mode 4 (base plus offset): one read at base + sign-extended field. The base is sp_val when req_use_sp=1 and reg_val otherwise. req_use_sp has no effect in any other mode.
- R7: Mode 5 (memory indirect): a read at the zero-extended field returns a pointer, then a read at that pointer returns the operand; ea_out is the pointer.
- R8: Mode 6 (register plus offset, indirect): a read at reg_val + sign-extended field returns a pointer, then a second read at the pointer returns the operand; ea_out is the pointer.
- R9: Mode 7 (PC displacement): ea_out = pc_val + sign-extended field, operand_out is 0, and no read is issued.
- R10: All address sums wrap modulo 2^AW.
- R11: At most one read is outstanding. mem_req is a one-cycle pulse. A chained read is issued in the cycle after the pointer's mem_rvalid. done rises in the cycle after the final mem_rvalid. A mem_rvalid with no read outstanding is ignored.
- R12: req_ready is low while reads are pending, and req_valid is ignored during that time. A request presented in the cycle done is high is accepted.
- R13: done is high for exactly one cycle per accepted request, and ea_out and operand_out hold their values until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_mode | input | 3 | Addressing mode code 0..7 |
| req_use_sp | input | 1 | Select stack pointer as base in mode 4 |
| reg_val | input | DW | Register-file read value |
| sp_val | input | AW | Stack pointer |
| pc_val | input | AW | Program counter |
| instr_field | input | OW | Offset / immediate / address field |
| req_ready | output | 1 | Unit idle, request can be accepted |
| mem_req | output | 1 | Memory read request pulse |
| mem_addr | output | AW | Memory read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data |
| ea_out | output | AW | Final effective address |
| operand_out | output | DW | Final operand value |
| done | output | 1 | Result valid strobe, one cycle |

## Verification
Two pairs of events can fall in the same cycle. In the first, one request reports done while the next request is being accepted. The bench holds req_valid high across the done cycle of an immediate request, switches the inputs to a register-mode request, and expects a second done with the new operand one cycle later. In the second, a memory response arrives while an unwanted req_valid is held during a chained read. The bench expects req_ready to stay low, only one done to appear, and the result to match the chained request alone. A stray mem_rvalid sent while idle must leave every output unchanged.

// File: rtl/eaddr_pkg.sv
package eaddr_pkg;

  typedef enum logic [2:0] {
    AM_IMM   = 3'd0,
    AM_REG   = 3'd1,
    AM_DIR   = 3'd2,
    AM_RIND  = 3'd3,
    AM_ROFS  = 3'd4,
    AM_MIND  = 3'd5,
    AM_ROIND = 3'd6,
    AM_PCREL = 3'd7
  } amode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PTR  = 2'd1,
    ST_DATA = 2'd2
  } seq_st_e;

endpackage

// File: rtl/eaddr_calc.sv
module eaddr_calc
  import eaddr_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int OW = 8
) (
  input  logic [2:0]    mode,
  input  logic          use_sp,
  input  logic [DW-1:0] reg_val,
  input  logic [AW-1:0] sp_val,
  input  logic [AW-1:0] pc_val,
  input  logic [OW-1:0] field,
  output logic [AW-1:0] first_addr,
  output logic [1:0]    n_reads,
  output logic [AW-1:0] imm_ea,
  output logic [DW-1:0] imm_op
);

  localparam int AXW = AW - OW;
  localparam int DXW = DW - OW;

  amode_e        m;
  logic [AW-1:0] off_sx;
  logic [AW-1:0] fld_zx;
  logic [DW-1:0] imm_sx;
  logic [AW-1:0] reg_addr;
  logic [AW-1:0] base;
  logic [AW-1:0] base_sum;

  assign m        = amode_e'(mode);
  assign off_sx   = {{AXW{field[OW-1]}}, field};
  assign fld_zx   = {{AXW{1'b0}}, field};
  assign imm_sx   = {{DXW{field[OW-1]}}, field};
  assign reg_addr = reg_val[AW-1:0];

  // the stack pointer replaces the register only for mode 4
  assign base     = (m == AM_ROFS && use_sp) ? sp_val : reg_addr;
  assign base_sum = base + off_sx;

  always_comb begin
    first_addr = '0;
    n_reads    = 2'd0;
    imm_ea     = '0;
    imm_op     = '0;
    case (m)
      AM_IMM:   imm_op = imm_sx;
      AM_REG:   imm_op = reg_val;
      AM_DIR:   begin first_addr = fld_zx;   n_reads = 2'd1; end
      AM_RIND:  begin first_addr = reg_addr; n_reads = 2'd1; end
      AM_ROFS:  begin first_addr = base_sum; n_reads = 2'd1; end
      AM_MIND:  begin first_addr = fld_zx;   n_reads = 2'd2; end
      AM_ROIND: begin first_addr = base_sum; n_reads = 2'd2; end
      AM_PCREL: imm_ea = pc_val + off_sx;
      default:  ;
    endcase
  end

  // R6: subtracting the stack pointer back out must leave the offset
  always_comb begin
    if (m == AM_ROFS && use_sp)
      assert_stack_base_R6: assert (first_addr - sp_val == off_sx);
  end

endmodule

// File: rtl/eaddr_seq.sv
module eaddr_seq
  import eaddr_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    n_reads,
  input  logic [AW-1:0] first_addr,
  input  logic [AW-1:0] imm_ea,
  input  logic [DW-1:0] imm_op,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          req_ready,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] ea_out,
  output logic [DW-1:0] op_out,
  output logic          done
);

  seq_st_e       st;
  logic          mem_req_q;
  logic [AW-1:0] mem_addr_q;
  logic [AW-1:0] ea_q;
  logic [DW-1:0] op_q;
  logic          done_q;

  assign req_ready = (st == ST_IDLE);
  assign mem_req   = mem_req_q;
  assign mem_addr  = mem_addr_q;
  assign ea_out    = ea_q;
  assign op_out    = op_q;
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      mem_req_q  <= 1'b0;
      mem_addr_q <= '0;
      ea_q       <= '0;
      op_q       <= '0;
      done_q     <= 1'b0;
    end else begin
      mem_req_q <= 1'b0;
      done_q    <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            if (n_reads == 2'd0) begin
              ea_q   <= imm_ea;
              op_q   <= imm_op;
              done_q <= 1'b1;
            end else begin
              mem_req_q  <= 1'b1;
              mem_addr_q <= first_addr;
              st         <= (n_reads == 2'd2) ? ST_PTR : ST_DATA;
            end
          end
        end
        ST_PTR: begin
          if (mem_rvalid) begin
            mem_req_q  <= 1'b1;
            mem_addr_q <= mem_rdata[AW-1:0];
            st         <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (mem_rvalid) begin
            ea_q   <= mem_addr_q;
            op_q   <= mem_rdata;
            done_q <= 1'b1;
            st     <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_zero_read_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && n_reads == 2'd0) |=> (done && !mem_req));

  assert_one_read_R11: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  assert_busy_ignore_R12: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && req_valid && !mem_rvalid) |=> (!done && !mem_req));

  assert_done_idle_R13: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready);

  assert_hold_R13: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(ea_out) && $stable(op_out)));

endmodule

// File: rtl/eaddr_resolver.sv
module eaddr_resolver
  import eaddr_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int OW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [2:0]    req_mode,
  input  logic          req_use_sp,
  input  logic [DW-1:0] reg_val,
  input  logic [AW-1:0] sp_val,
  input  logic [AW-1:0] pc_val,
  input  logic [OW-1:0] instr_field,
  output logic          req_ready,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] ea_out,
  output logic [DW-1:0] operand_out,
  output logic          done
);

  logic [AW-1:0] first_addr;
  logic [1:0]    n_reads;
  logic [AW-1:0] imm_ea;
  logic [DW-1:0] imm_op;

  eaddr_calc #(.AW(AW), .DW(DW), .OW(OW)) u_calc (
    .mode       (req_mode),
    .use_sp     (req_use_sp),
    .reg_val    (reg_val),
    .sp_val     (sp_val),
    .pc_val     (pc_val),
    .field      (instr_field),
    .first_addr (first_addr),
    .n_reads    (n_reads),
    .imm_ea     (imm_ea),
    .imm_op     (imm_op)
  );

  eaddr_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .n_reads    (n_reads),
    .first_addr (first_addr),
    .imm_ea     (imm_ea),
    .imm_op     (imm_op),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .req_ready  (req_ready),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .ea_out     (ea_out),
    .op_out     (operand_out),
    .done       (done)
  );

endmodule

// File: tb/test_eaddr_resolver.sv
`timescale 1ns/1ps
module test_eaddr_resolver;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_mode = '0;
  logic        req_use_sp = 1'b0;
  logic [15:0] reg_val = '0;
  logic [15:0] sp_val = '0;
  logic [15:0] pc_val = '0;
  logic [7:0]  instr_field = '0;
  logic        req_ready;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic [15:0] ea_out;
  logic [15:0] operand_out;
  logic        done;

  int n_chk = 0;
  int n_bad = 0;
  int lat = 2;
  logic stray = 1'b0;

  int cnt = 0;
  logic [15:0] addr_l = '0;
  int cyc = 0;
  int last_rv = 0;
  int rd_total = 0;
  int done_total = 0;

  always #2.5 clk = ~clk;

  eaddr_resolver #(.AW(16), .DW(16), .OW(8)) i_eaddr_resolver (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .req_use_sp(req_use_sp), .reg_val(reg_val), .sp_val(sp_val),
    .pc_val(pc_val), .instr_field(instr_field), .req_ready(req_ready),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .ea_out(ea_out), .operand_out(operand_out),
    .done(done)
  );

  function automatic logic [15:0] mval(input logic [15:0] a);
    logic [31:0] t;
    t = {16'h0, a} * 32'h9E37 + 32'h3C1B;
    return t[15:0];
  endfunction

  // memory model with programmable latency; bench-side only
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rvalid) last_rv <= cyc;
    if (mem_req) rd_total <= rd_total + 1;
    if (done) done_total <= done_total + 1;
    if (mem_req) begin
      addr_l <= mem_addr;
      cnt    <= lat;
    end else if (cnt != 0) begin
      cnt <= cnt - 1;
    end
    mem_rvalid <= (cnt == 1 && !mem_req) || stray;
    mem_rdata  <= stray ? 16'hDEAD : mval(addr_l);
  end

  // {reads, ea, op}
  function automatic logic [33:0] model(input logic [2:0] m, input logic u,
      input logic [15:0] r, input logic [15:0] s, input logic [15:0] p,
      input logic [7:0] f);
    logic [15:0] so;
    logic [15:0] zo;
    logic [15:0] a;
    logic [15:0] ptr;
    so = {{8{f[7]}}, f};
    zo = {8'h00, f};
    case (m)
      3'd0: return {2'd0, 16'h0, so};
      3'd1: return {2'd0, 16'h0, r};
      3'd2: begin a = zo; return {2'd1, a, mval(a)}; end
      3'd3: begin a = r; return {2'd1, a, mval(a)}; end
      3'd4: begin a = (u ? s : r) + so; return {2'd1, a, mval(a)}; end
      3'd5: begin a = zo; ptr = mval(a); return {2'd2, ptr, mval(ptr)}; end
      3'd6: begin a = r + so; ptr = mval(a); return {2'd2, ptr, mval(ptr)}; end
      default: return {2'd0, p + so, 16'h0};
    endcase
  endfunction

  localparam logic [59:0] VEC [0:11] = '{
    {3'd0, 1'b0, 16'h0000, 16'h0000, 16'h0000, 8'h85},
    {3'd1, 1'b0, 16'h1234, 16'h0000, 16'h0000, 8'h00},
    {3'd2, 1'b0, 16'h0000, 16'h0000, 16'h0000, 8'h40},
    {3'd3, 1'b0, 16'h2222, 16'h0000, 16'h0000, 8'h00},
    {3'd4, 1'b0, 16'h1000, 16'h0000, 16'h0000, 8'hF0},
    {3'd4, 1'b1, 16'h1111, 16'h8000, 16'h0000, 8'h10},
    {3'd5, 1'b0, 16'h0000, 16'h0000, 16'h0000, 8'h33},
    {3'd6, 1'b0, 16'h0400, 16'h0000, 16'h0000, 8'h04},
    {3'd7, 1'b0, 16'h0000, 16'h0000, 16'h0100, 8'h7F},
    {3'd3, 1'b1, 16'h0ABC, 16'hFFFF, 16'h0000, 8'h00},
    {3'd4, 1'b1, 16'h0000, 16'hFFF0, 16'h0000, 8'h20},
    {3'd7, 1'b0, 16'h0000, 16'h0000, 16'h0005, 8'h80}
  };

  string TAG [0:11] = '{"R2", "R3", "R4", "R5", "R6", "R6", "R7", "R8",
                        "R9", "R6", "R10", "R10"};

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [59:0] v);
    req_mode    = v[59:57];
    req_use_sp  = v[56];
    reg_val     = v[55:40];
    sp_val      = v[39:24];
    pc_val      = v[23:8];
    instr_field = v[7:0];
  endtask

  task automatic run_vec(input logic [59:0] v, input string tg);
    logic [33:0] e;
    int base_rd;
    int w;
    e = model(v[59:57], v[56], v[55:40], v[39:24], v[23:8], v[7:0]);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    drive(v);
    req_valid = 1'b1;
    base_rd = rd_total;
    @(negedge clk);
    req_valid = 1'b0;
    w = 0;
    while (!done && w < 100) begin @(negedge clk); w++; end
    chk(done, tg, "done seen", {31'h0, done}, 32'h1);
    chk(ea_out == e[31:16], tg, "ea_out", {16'h0, ea_out}, {16'h0, e[31:16]});
    chk(operand_out == e[15:0], tg, "operand", {16'h0, operand_out}, {16'h0, e[15:0]});
    chk(rd_total - base_rd == int'(e[33:32]), tg, "read count",
        rd_total - base_rd, {30'h0, e[33:32]});
    if (e[33:32] != 2'd0)
      chk(cyc == last_rv + 1, "R11", "done after last rvalid", cyc, last_rv + 1);
    @(negedge clk);
    chk(!done, "R13", "done width", {31'h0, done}, 32'h0);
    chk(ea_out == e[31:16] && operand_out == e[15:0], "R13", "hold",
        {ea_out, operand_out}, e[31:0]);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R11 watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [33:0] e;
    logic [15:0] ea_h;
    logic [15:0] op_h;
    int dt;
    int rd0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !done && !mem_req && ea_out == 0 && operand_out == 0, "R1",
        "reset state", {req_ready, done, mem_req, ea_out, operand_out[12:0]},
        {3'b100, 29'h0});

    for (int i = 0; i < 12; i++) begin
      lat = 1 + (i % 3);
      run_vec(VEC[i], TAG[i]);
    end

    // R12: req_valid held while a chained read is pending is ignored
    lat = 3;
    e = model(3'd5, 1'b0, 16'h0, 16'h0, 16'h0, 8'h5A);
    dt = done_total;
    @(negedge clk);
    drive({3'd5, 1'b0, 16'h0, 16'h0, 16'h0, 8'h5A});
    req_valid = 1'b1;
    @(negedge clk);
    drive({3'd0, 1'b0, 16'h0, 16'h0, 16'h0, 8'h11});
    chk(!req_ready, "R12", "ready low while busy", {31'h0, req_ready}, 32'h0);
    while (!done) @(negedge clk);
    req_valid = 1'b0;
    chk(ea_out == e[31:16] && operand_out == e[15:0], "R12", "busy result",
        {ea_out, operand_out}, e[31:0]);
    repeat (3) @(negedge clk);
    chk(done_total - dt == 1, "R12", "single done", done_total - dt, 1);

    // R12/R13: request accepted in the done cycle
    drive({3'd0, 1'b0, 16'h0, 16'h0, 16'h0, 8'h22});
    req_valid = 1'b1;
    @(negedge clk);
    chk(done && req_ready && operand_out == 16'h0022, "R12", "first done",
        {done, req_ready, operand_out}, {2'b11, 16'h0022});
    drive({3'd1, 1'b0, 16'hBEEF, 16'h0, 16'h0, 8'h00});
    @(negedge clk);
    req_valid = 1'b0;
    chk(done && operand_out == 16'hBEEF, "R12", "back-to-back done",
        {done, operand_out}, {1'b1, 16'hBEEF});
    repeat (3) begin
      @(negedge clk);
      chk(!done && operand_out == 16'hBEEF && ea_out == 16'h0, "R13",
          "hold after done", {done, operand_out}, {1'b0, 16'hBEEF});
    end

    // R11: stray rvalid while idle
    ea_h = ea_out;
    op_h = operand_out;
    rd0 = rd_total;
    dt = done_total;
    stray = 1'b1;
    @(negedge clk);
    stray = 1'b0;
    repeat (3) @(negedge clk);
    chk(done_total == dt && req_ready && ea_out == ea_h && operand_out == op_h
        && rd_total == rd0, "R11", "stray rvalid ignored",
        {done_total - dt, 15'h0, operand_out}, {16'h0, op_h});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule